// File: doc/BRIEF.md
# Write-Only Two-Wire Register Target

This block is a two-wire serial bus target that only accepts write transfers. It runs entirely in the system clock domain. The bus clock and data lines are sampled through synchronizers, and START, STOP and bit edges are found by comparing each sampled level with the one before it. The block answers to a 7-bit device address. Its upper five bits are fixed and its two lowest bits come from a strap input. It acknowledges every byte it accepts by pulling the data line low during the ninth clock.

The first byte after the device address selects a register. Each following data byte is written to that register, and the register pointer then advances by one. One transfer can therefore fill a run of consecutive registers.

Some registers take effect as soon as they are written. These are a run/standby bit and four configuration bytes. The LED-enable byte and six duty bytes are double-buffered: writes go to a staging copy, and a zero written to a load address copies the staging group into the active group. Fourteen timing bytes are staged in the same way and have a load address of their own. A zero written to a clear address returns every register, staging and active, to its default value.

A separate wake input acts on its rising edge. It returns the bus state machine to idle but leaves every register unchanged.

Top module: `i2c_wo_regbank`

## Requirements
- R1: The target acknowledges only the address byte {1,1,0,0,1,strap[1],strap[0],0}, sent most significant bit first. An address byte with a different strap value, or with the last (read/write) bit set to 1, is not acknowledged. The bytes that follow it, up to the next START, change no register.
- R2: When it accepts an address byte, a register byte or a data byte, the target holds the data line low throughout the ninth clock of that byte.
- R3: After each data byte the register pointer increases by one (modulo 256). Successive data bytes in one transfer therefore land in successive registers.
- R4: Register 0x00 bit 0 drives `run_o` (1 = run, 0 = standby). Registers 0x03 to 0x06 drive `cfg_o` bytes 0 to 3. Both change as soon as the data byte is accepted.
- R5: Writes to 0x01 (LED enable) and to 0x07 to 0x0C (duty bytes 0 to 5) go to a staging copy. They reach `led_en_o` and `duty_o` only when 0x00 is written to 0x10. Any other value written to 0x10 has no effect.
- R6: Writes to 0x11 to 0x16 (timing slots 0 to 5), 0x1A to 0x1B (slots 6 and 7) and 0x1D to 0x22 (slots 8 to 13) are staged. They reach `timing_o` only when 0x00 is written to 0x26.
- R7: Writing 0x00 to 0xFF returns every staging and active register to its default value. The LED-enable default is 0x77; every other default is 0. Any other value written to 0xFF has no effect.
- R8: A rising edge on `wake_i` returns the bus state machine to idle, so the rest of the current transfer is neither acknowledged nor written. Register contents are kept.
- R9: A STOP or START that arrives before the eighth bit of a byte is complete abandons that byte, and no register is written. A START begins a new address phase.
- R10: After `rst_n_i` is asserted, `bus_dat_pull_o` is 0, `led_en_o` is 0x77, and every other register output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock line level |
| bus_dat_i | input | 1 | Serial bus data line level |
| bus_dat_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| wake_i | input | 1 | Rising edge returns the bus logic to idle |
| addr_strap_i | input | 2 | Low two bits of the device address |
| run_o | output | 1 | Run (1) or standby (0) |
| cfg_o | output | 32 | Four immediate configuration bytes, byte k at bits 8k+7:8k |
| led_en_o | output | 8 | Active LED-enable byte |
| duty_o | output | 48 | Six active duty bytes, byte k at bits 8k+7:8k |
| timing_o | output | 112 | Fourteen active timing bytes, slot k at bits 8k+7:8k |

## Verification
Bus lines reach the state machine after two synchronizer stages and one edge-compare stage. The acknowledge pull therefore appears about four system cycles after the bus clock falls at the end of the eighth bit. A register write or group load lands one cycle after that. The bench holds each bus clock phase for 16 system cycles and samples the acknowledge in the middle of the ninth clock's high phase, well after the pull has settled. It compares register outputs only after the STOP plus a short settling delay, when every write of the transfer is certain to have landed.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int N_CFG  = 4;
  localparam int N_DUTY = 6;
  localparam int N_TIM  = 14;

  localparam logic [4:0] DEV_PREFIX = 5'b11001;

  localparam logic [7:0] A_RUN      = 8'h00;
  localparam logic [7:0] A_LED      = 8'h01;
  localparam logic [7:0] A_CFG0     = 8'h03;
  localparam logic [7:0] A_DUTY0    = 8'h07;
  localparam logic [7:0] A_LOAD_OUT = 8'h10;
  localparam logic [7:0] A_TIM_A0   = 8'h11;
  localparam logic [7:0] A_TIM_B0   = 8'h1A;
  localparam logic [7:0] A_TIM_C0   = 8'h1D;
  localparam logic [7:0] A_LOAD_TIM = 8'h26;
  localparam logic [7:0] A_CLEAR    = 8'hFF;

  localparam logic [7:0] LED_DEFAULT = 8'h77;
  localparam logic [4:0] NO_SLOT     = 5'h1F;

  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_ACK_A, L_REG, L_ACK_R, L_DATA, L_ACK_D, L_SKIP
  } link_st_t;

  function automatic logic addr_hit(input logic [7:0] b, input logic [1:0] strap);
    return b == {DEV_PREFIX, strap, 1'b0};
  endfunction

  function automatic logic in_span(input logic [7:0] a, input logic [7:0] base,
                                   input logic [7:0] n);
    return (a >= base) && ((a - base) < n);
  endfunction

  // maps a register address onto a timing slot, NO_SLOT when none
  function automatic logic [4:0] tim_slot(input logic [7:0] a);
    if (in_span(a, A_TIM_A0, 8'd6)) return 5'(a - A_TIM_A0);
    if (in_span(a, A_TIM_B0, 8'd2)) return 5'(a - A_TIM_B0 + 8'd6);
    if (in_span(a, A_TIM_C0, 8'd6)) return 5'(a - A_TIM_C0 + 8'd8);
    return NO_SLOT;
  endfunction
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pipe_q <= {STAGES{IDLE_VAL}};
      prev_q <= IDLE_VAL;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], async_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/i2cw_link.sv
module i2cw_link
  import i2cw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             scl_l_i,
  input  logic             scl_p_i,
  input  logic             sda_l_i,
  input  logic             sda_p_i,
  input  logic             wake_l_i,
  input  logic             wake_p_i,
  input  logic [1:0]       strap_i,
  output logic             pull_o,
  output logic             wr_fire_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic             stop_o,
  output logic             wake_o,
  output logic             busy_o
);
  link_st_t st_q;
  logic [BYTE_W-1:0] shift_q, ptr_q;
  logic [3:0] bits_q;

  logic scl_rise, scl_fall, start_w, stop_w, wake_w, byte_done, rx_state;
  assign scl_rise  = scl_l_i & ~scl_p_i;
  assign scl_fall  = ~scl_l_i & scl_p_i;
  assign start_w   = scl_l_i & scl_p_i & sda_p_i & ~sda_l_i;
  assign stop_w    = scl_l_i & scl_p_i & ~sda_p_i & sda_l_i;
  assign wake_w    = wake_l_i & ~wake_p_i;
  assign byte_done = (bits_q == 4'd8);
  assign rx_state  = (st_q == L_ADDR) || (st_q == L_REG) || (st_q == L_DATA);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q      <= L_IDLE;
      shift_q   <= '0;
      ptr_q     <= '0;
      bits_q    <= '0;
      pull_o    <= 1'b0;
      wr_fire_o <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_fire_o <= 1'b0;
      if (wake_w || stop_w) begin
        st_q   <= L_IDLE;
        pull_o <= 1'b0;
        bits_q <= '0;
      end else if (start_w) begin
        st_q   <= L_ADDR;
        pull_o <= 1'b0;
        bits_q <= '0;
      end else if (rx_state) begin
        if (scl_rise && !byte_done) begin
          shift_q <= {shift_q[BYTE_W-2:0], sda_l_i};
          bits_q  <= bits_q + 4'd1;
        end else if (scl_fall && byte_done) begin
          bits_q <= '0;
          if (st_q == L_ADDR) begin
            if (addr_hit(shift_q, strap_i)) begin
              pull_o <= 1'b1;
              st_q   <= L_ACK_A;
            end else begin
              st_q <= L_SKIP;
            end
          end else if (st_q == L_REG) begin
            ptr_q  <= shift_q;
            pull_o <= 1'b1;
            st_q   <= L_ACK_R;
          end else begin
            wr_fire_o <= 1'b1;
            wr_addr_o <= ptr_q;
            wr_data_o <= shift_q;
            ptr_q     <= ptr_q + 8'd1;
            pull_o    <= 1'b1;
            st_q      <= L_ACK_D;
          end
        end
      end else if ((st_q == L_ACK_A || st_q == L_ACK_R || st_q == L_ACK_D) && scl_fall) begin
        pull_o <= 1'b0;
        st_q   <= (st_q == L_ACK_A) ? L_REG : L_DATA;
      end
    end
  end

  assign stop_o = stop_w;
  assign wake_o = wake_w;
  assign busy_o = (st_q != L_IDLE);
endmodule

// File: rtl/i2cw_bank.sv
module i2cw_bank
  import i2cw_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     wr_fire_i,
  input  logic [BYTE_W-1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  output logic                     run_o,
  output logic [N_CFG*BYTE_W-1:0]  cfg_o,
  output logic [BYTE_W-1:0]        led_en_o,
  output logic [N_DUTY*BYTE_W-1:0] duty_o,
  output logic [N_TIM*BYTE_W-1:0]  timing_o
);
  logic zero_w, clear_w, load_out_w, load_tim_w;
  logic [4:0] slot_w;
  assign zero_w     = (wr_data_i == '0);
  assign clear_w    = wr_fire_i && (wr_addr_i == A_CLEAR) && zero_w;
  assign load_out_w = wr_fire_i && (wr_addr_i == A_LOAD_OUT) && zero_w;
  assign load_tim_w = wr_fire_i && (wr_addr_i == A_LOAD_TIM) && zero_w;
  assign slot_w     = tim_slot(wr_addr_i);

  logic run_q;
  logic [BYTE_W-1:0] led_stg_q, led_act_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      run_q     <= 1'b0;
      led_stg_q <= LED_DEFAULT;
      led_act_q <= LED_DEFAULT;
    end else if (clear_w) begin
      run_q     <= 1'b0;
      led_stg_q <= LED_DEFAULT;
      led_act_q <= LED_DEFAULT;
    end else begin
      if (wr_fire_i && wr_addr_i == A_RUN) run_q <= wr_data_i[0];
      if (wr_fire_i && wr_addr_i == A_LED) led_stg_q <= wr_data_i;
      if (load_out_w) led_act_q <= led_stg_q;
    end
  end
  assign run_o    = run_q;
  assign led_en_o = led_act_q;

  for (genvar k = 0; k < N_CFG; k++) begin : g_cfg
    logic [BYTE_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) val_q <= '0;
      else if (clear_w) val_q <= '0;
      else if (wr_fire_i && wr_addr_i == A_CFG0 + 8'(k)) val_q <= wr_data_i;
    end
    assign cfg_o[k*BYTE_W +: BYTE_W] = val_q;
  end

  for (genvar k = 0; k < N_DUTY; k++) begin : g_duty
    logic [BYTE_W-1:0] stg_q, act_q;
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        stg_q <= '0;
        act_q <= '0;
      end else if (clear_w) begin
        stg_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_fire_i && wr_addr_i == A_DUTY0 + 8'(k)) stg_q <= wr_data_i;
        if (load_out_w) act_q <= stg_q;
      end
    end
    assign duty_o[k*BYTE_W +: BYTE_W] = act_q;
  end

  for (genvar k = 0; k < N_TIM; k++) begin : g_tim
    logic [BYTE_W-1:0] stg_q, act_q;
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        stg_q <= '0;
        act_q <= '0;
      end else if (clear_w) begin
        stg_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_fire_i && slot_w == 5'(k)) stg_q <= wr_data_i;
        if (load_tim_w) act_q <= stg_q;
      end
    end
    assign timing_o[k*BYTE_W +: BYTE_W] = act_q;
  end
endmodule

// File: rtl/i2c_wo_regbank.sv
module i2c_wo_regbank
  import i2cw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     bus_clk_i,
  input  logic                     bus_dat_i,
  output logic                     bus_dat_pull_o,
  input  logic                     wake_i,
  input  logic [1:0]               addr_strap_i,
  output logic                     run_o,
  output logic [N_CFG*BYTE_W-1:0]  cfg_o,
  output logic [BYTE_W-1:0]        led_en_o,
  output logic [N_DUTY*BYTE_W-1:0] duty_o,
  output logic [N_TIM*BYTE_W-1:0]  timing_o
);
  localparam int N_LINES = 3;

  logic [N_LINES-1:0] line_lvl, line_prev;
  logic wr_fire, stop_evt, wake_evt, link_busy;
  logic [BYTE_W-1:0] wr_addr, wr_data;

  i2cw_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .IDLE_VAL(3'b011)) sync_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .async_i ({wake_i, bus_clk_i, bus_dat_i}),
    .lvl_o   (line_lvl),
    .prev_o  (line_prev)
  );

  i2cw_link link_i (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .scl_l_i   (line_lvl[1]),
    .scl_p_i   (line_prev[1]),
    .sda_l_i   (line_lvl[0]),
    .sda_p_i   (line_prev[0]),
    .wake_l_i  (line_lvl[2]),
    .wake_p_i  (line_prev[2]),
    .strap_i   (addr_strap_i),
    .pull_o    (bus_dat_pull_o),
    .wr_fire_o (wr_fire),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .stop_o    (stop_evt),
    .wake_o    (wake_evt),
    .busy_o    (link_busy)
  );

  i2cw_bank bank_i (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .wr_fire_i (wr_fire),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .run_o     (run_o),
    .cfg_o     (cfg_o),
    .led_en_o  (led_en_o),
    .duty_o    (duty_o),
    .timing_o  (timing_o)
  );
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk
  import i2cw_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_n_i,
  input logic                    pull_i,
  input logic                    busy_i,
  input logic                    stop_i,
  input logic                    wake_i,
  input logic                    wr_fire_i,
  input logic [BYTE_W-1:0]       wr_addr_i,
  input logic [BYTE_W-1:0]       wr_data_i,
  input logic [BYTE_W-1:0]       led_i,
  input logic [N_CFG*BYTE_W-1:0] cfg_i,
  input logic [N_TIM*BYTE_W-1:0] tim_i
);
  // R8
  wake_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wake_i |=> (!busy_i && !pull_i));

  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    stop_i |=> (!busy_i && !pull_i));

  // R2
  pull_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pull_i |-> busy_i);

  // R5
  led_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(led_i) |-> $past(wr_fire_i && wr_data_i == 8'h00 &&
                              (wr_addr_i == A_LOAD_OUT || wr_addr_i == A_CLEAR)));

  // R6
  tim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(tim_i) |-> $past(wr_fire_i && wr_data_i == 8'h00 &&
                              (wr_addr_i == A_LOAD_TIM || wr_addr_i == A_CLEAR)));

  // R4
  cfg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(cfg_i) |-> $past(wr_fire_i));

  // R7
  clear_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_fire_i && wr_addr_i == A_CLEAR && wr_data_i == 8'h00) |=>
      (led_i == LED_DEFAULT && tim_i == '0 && cfg_i == '0));
endmodule

bind i2c_wo_regbank i2cw_chk chk_i (
  .clk_i     (clk_i),
  .rst_n_i   (rst_n_i),
  .pull_i    (bus_dat_pull_o),
  .busy_i    (link_busy),
  .stop_i    (stop_evt),
  .wake_i    (wake_evt),
  .wr_fire_i (wr_fire),
  .wr_addr_i (wr_addr),
  .wr_data_i (wr_data),
  .led_i     (led_en_o),
  .cfg_i     (cfg_o),
  .tim_i     (timing_o)
);

// File: tb/i2c_wo_regbank_tb_top.sv
module i2c_wo_regbank_tb_top;
  localparam int HALF = 16;
  localparam int Q = 8;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic wake = 1'b0;
  logic pull;
  logic line;
  logic run;
  logic [31:0] cfg;
  logic [7:0] led;
  logic [47:0] duty;
  logic [111:0] tim;

  always #10 clk = ~clk;
  assign line = ~(m_low | pull);

  i2c_wo_regbank dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .bus_clk_i(m_scl), .bus_dat_i(line),
    .bus_dat_pull_o(pull), .wake_i(wake), .addr_strap_i(STRAP),
    .run_o(run), .cfg_o(cfg), .led_en_o(led), .duty_o(duty), .timing_o(tim)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model of the register file
  logic       e_run;
  logic [7:0] e_cfg [4];
  logic [7:0] e_led_s, e_led_a;
  logic [7:0] e_duty_s [6];
  logic [7:0] e_duty_a [6];
  logic [7:0] e_tim_s [14];
  logic [7:0] e_tim_a [14];

  function automatic int t_slot(input logic [7:0] a);
    if (a >= 8'h11 && a <= 8'h16) return int'(a) - 17;
    if (a == 8'h1A || a == 8'h1B) return int'(a) - 26 + 6;
    if (a >= 8'h1D && a <= 8'h22) return int'(a) - 29 + 8;
    return -1;
  endfunction

  task automatic model_clear();
    e_run = 1'b0; e_led_s = 8'h77; e_led_a = 8'h77;
    for (int k = 0; k < 4; k++) e_cfg[k] = 8'h00;
    for (int k = 0; k < 6; k++) begin e_duty_s[k] = 8'h00; e_duty_a[k] = 8'h00; end
    for (int k = 0; k < 14; k++) begin e_tim_s[k] = 8'h00; e_tim_a[k] = 8'h00; end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    int s;
    s = t_slot(a);
    if (a == 8'h00) e_run = d[0];
    else if (a == 8'h01) e_led_s = d;
    else if (a >= 8'h03 && a <= 8'h06) e_cfg[a - 8'h03] = d;
    else if (a >= 8'h07 && a <= 8'h0C) e_duty_s[a - 8'h07] = d;
    else if (a == 8'h10 && d == 8'h00) begin
      e_led_a = e_led_s;
      for (int k = 0; k < 6; k++) e_duty_a[k] = e_duty_s[k];
    end else if (a == 8'h26 && d == 8'h00) begin
      for (int k = 0; k < 14; k++) e_tim_a[k] = e_tim_s[k];
    end else if (a == 8'hFF && d == 8'h00) model_clear();
    else if (s >= 0) e_tim_s[s] = d;
  endtask

  task automatic check(input string req, input logic [111:0] got, input logic [111:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic check_regs(input string req);
    logic [31:0] xc;
    logic [47:0] xd;
    logic [111:0] xt;
    for (int k = 0; k < 4; k++) xc[k*8 +: 8] = e_cfg[k];
    for (int k = 0; k < 6; k++) xd[k*8 +: 8] = e_duty_a[k];
    for (int k = 0; k < 14; k++) xt[k*8 +: 8] = e_tim_a[k];
    check({req, " run"}, 112'(run), 112'(e_run));
    check({req, " cfg"}, 112'(cfg), 112'(xc));
    check({req, " led"}, 112'(led), 112'(e_led_a));
    check({req, " duty"}, 112'(duty), 112'(xd));
    check({req, " timing"}, tim, xt);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wait_n(Q); m_scl = 1'b1; wait_n(Q);
    m_low = 1'b1; wait_n(Q); m_scl = 1'b0; wait_n(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wait_n(Q); m_scl = 1'b1; wait_n(Q);
    m_low = 1'b0; wait_n(Q);
  endtask

  task automatic bit_out(input logic b);
    m_low = ~b; wait_n(Q); m_scl = 1'b1; wait_n(HALF); m_scl = 1'b0; wait_n(Q);
  endtask

  task automatic bits_out(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) bit_out(b[i]);
  endtask

  task automatic byte_out(input logic [7:0] b, output logic ack_n);
    bits_out(b, 8);
    m_low = 1'b0; wait_n(Q); m_scl = 1'b1; wait_n(Q);
    ack_n = line;
    wait_n(Q); m_scl = 1'b0; wait_n(Q);
  endtask

  function automatic logic [7:0] dev_byte(input logic [1:0] s, input logic rw);
    return {5'b11001, s, rw};
  endfunction

  // full write transfer: byte i of dat goes to reg a+i
  task automatic write_txn(input logic [7:0] a, input logic [63:0] dat, input int n);
    logic ack;
    bus_start();
    byte_out(dev_byte(STRAP, 1'b0), ack); check("R2 address ack", 112'(ack), 112'(0));
    byte_out(a, ack);                     check("R2 register ack", 112'(ack), 112'(0));
    for (int i = 0; i < n; i++) begin
      byte_out(dat[8*i +: 8], ack);
      check("R2 data ack", 112'(ack), 112'(0));
      model_write(a + 8'(i), dat[8*i +: 8]);
    end
    bus_stop();
    wait_n(8);
  endtask

  initial begin
    logic ack;
    logic [7:0] pool [27];
    pool = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09,
             8'h0A, 8'h0B, 8'h0C, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16,
             8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22, 8'h26};
    void'($urandom(32'd4242));
    model_clear();
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R10 reset state
    check("R10 pull", 112'(pull), 112'(0));
    check_regs("R10");

    // R4 direct registers, R3 increment across 0x03..0x06
    write_txn(8'h00, 64'h01, 1);
    check_regs("R4 run");
    write_txn(8'h03, 64'hD4C3B2A1, 4);
    check_regs("R3 R4 cfg burst");

    // R5 staged LED and duty
    write_txn(8'h07, 64'h665544332211, 6);
    write_txn(8'h01, 64'h05, 1);
    check_regs("R5 staged hold");
    write_txn(8'h10, 64'h5A, 1);
    check_regs("R5 nonzero load ignored");
    write_txn(8'h10, 64'h00, 1);
    check_regs("R5 load");
    check("R5 duty byte 5", 112'(duty[47:40]), 112'(8'h66));

    // R6 staged timing
    write_txn(8'h11, 64'h161514131211, 6);
    write_txn(8'h1A, 64'h2B2A, 2);
    write_txn(8'h1D, 64'h3D3C3B3A3938, 6);
    check_regs("R6 staged hold");
    write_txn(8'h26, 64'h00, 1);
    check_regs("R6 load");
    check("R6 slot 13", 112'(tim[111:104]), 112'(8'h3D));

    // R1 strap mismatch and read bit
    bus_start();
    byte_out(dev_byte(~STRAP, 1'b0), ack); check("R1 wrong strap nack", 112'(ack), 112'(1));
    byte_out(8'h03, ack);
    byte_out(8'hEE, ack);
    bus_stop(); wait_n(8);
    check_regs("R1 wrong strap no write");
    bus_start();
    byte_out(dev_byte(STRAP, 1'b1), ack); check("R1 read bit nack", 112'(ack), 112'(1));
    byte_out(8'h04, ack);
    byte_out(8'hEE, ack);
    bus_stop(); wait_n(8);
    check_regs("R1 read bit no write");

    // R9 stop and start inside a byte
    bus_start();
    byte_out(dev_byte(STRAP, 1'b0), ack);
    byte_out(8'h03, ack);
    bits_out(8'h99, 4);
    bus_stop(); wait_n(8);
    check_regs("R9 stop mid byte");
    bus_start();
    byte_out(dev_byte(STRAP, 1'b0), ack);
    byte_out(8'h04, ack);
    bits_out(8'h88, 3);
    bus_start();
    byte_out(dev_byte(STRAP, 1'b0), ack); check("R9 restart ack", 112'(ack), 112'(0));
    byte_out(8'h05, ack);
    byte_out(8'hC3, ack);
    model_write(8'h05, 8'hC3);
    bus_stop(); wait_n(8);
    check_regs("R9 restart mid byte");

    // R8 wake edge mid transfer
    bus_start();
    byte_out(dev_byte(STRAP, 1'b0), ack);
    byte_out(8'h06, ack);
    wake = 1'b1; wait_n(4); wake = 1'b0; wait_n(4);
    byte_out(8'h99, ack); check("R8 no ack after wake", 112'(ack), 112'(1));
    bus_stop(); wait_n(8);
    check_regs("R8 registers kept");
    write_txn(8'h06, 64'h7E, 1);
    check_regs("R8 bus usable");

    // random mix
    for (int t = 0; t < 30; t++) begin
      logic [7:0] a;
      logic [63:0] d;
      int n;
      a = pool[$urandom_range(0, 26)];
      n = $urandom_range(1, 3);
      d = {$urandom, $urandom};
      for (int i = 0; i < n; i++)
        if ((a + 8'(i) == 8'h10 || a + 8'(i) == 8'h26) && $urandom_range(0, 1) == 0)
          d[8*i +: 8] = 8'h00;
      write_txn(a, d, n);
      check_regs("R3 R4 R5 R6 random");
    end

    // R7 clear, nonzero first
    write_txn(8'hFF, 64'h01, 1);
    check_regs("R7 nonzero clear ignored");
    write_txn(8'hFF, 64'h00, 1);
    check_regs("R7 clear");
    check("R7 led default", 112'(led), 112'(8'h77));
    write_txn(8'h10, 64'h00, 1);
    write_txn(8'h26, 64'h00, 1);
    check_regs("R7 staging cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule